// File: doc/BRIEF.md
# Windowed Transposing Readout Address Sequencer

This block produces the order in which pixels of a 640 by 512 snapshot array are read out. A rising edge on the frame-sync input starts a frame and captures the configuration. Each later rising edge on the line-sync input streams one line of the window, one pixel per clock. For every pixel the block presents its row and column address, together with a one-hot lane flag that says which of the 1, 2 or 4 output lanes carries it.

The window origin and size are given in 4-pixel units. The window is then snapped to the column step that the lane count needs, held to a minimum size, and clipped at the array edge. Two order bits choose which corner is read first. An interlace bit reads all even rows of the window first and then all odd rows. Each pixel's lane depends only on its physical column, so it is the same for every scan direction and every window.

Top module: `rdsq_readout_seq`

## Requirements
- R1: While reset is asserted, and afterwards until the first frame-sync rising edge, no lane flag, line-done or frame-done is raised, and line-sync pulses start nothing.
- R2: Lanes L = 1, 2 or 4 (see R5) set the column step Q = 4·L pixels. Column start = field·4 rounded down to a multiple of Q. Column width = field·4, or 640 when the field is 0, rounded down to a multiple of Q and raised to at least 8·Q. Row start = field·4. Row height = field·4, or 512 when the field is 0, and at least 8 rows. A start is lowered so that the minimum size fits. The window end is clipped at column 640 and row 512. Every output address lies inside the window.
- R3: Order bit 0 set reads rows from the top of the window downward; otherwise rows go upward. Order bit 1 set reads each line from right to left; otherwise left to right. So code 00 starts at the lower-left corner, 01 at upper-left, 10 at lower-right and 11 at upper-right.
- R4: With interlace set, the even rows of the window are read first and then the odd rows, each pass in the direction that R3 selects.
- R5: Lane code 00 gives 1 lane, 01 gives 2 and 1x gives 4. During a pixel, exactly bit (column mod L) of the lane flags is set.
- R6: A line-sync rising edge while armed makes the first pixel appear in the next cycle. One pixel follows per clock, line-done is high with the last pixel, and the cycle after it has no pixel.
- R7: Frame-done is high only with the last pixel of the frame's last line. After it, line-sync pulses produce no pixels until the next frame-sync rising edge.
- R8: A line-sync rising edge during a line in progress is ignored: the line keeps its width and the next line comes out normally.
- R9: Configuration inputs are sampled only at a frame-sync rising edge. Changes during a frame have no effect on it.
- R10: A frame-sync rising edge at any time restarts the frame at its first row.
- R11: Within a line the row address is constant, and the column steps by exactly one in the direction that R3 selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync | input | 1 | Frame sync; a rising edge starts a frame |
| lsync | input | 1 | Line sync; a rising edge reads one line |
| cfg_col_start | input | 8 | Window column origin, 4-pixel units |
| cfg_col_size | input | 8 | Window width, 4-pixel units, 0 = full |
| cfg_row_start | input | 7 | Window row origin, 4-row units |
| cfg_row_size | input | 7 | Window height, 4-row units, 0 = full |
| cfg_order | input | 2 | Bit 0 row invert, bit 1 column revert |
| cfg_interlace | input | 1 | Even rows first, then odd rows |
| cfg_lanes | input | 2 | Lane count code |
| row_addr | output | 9 | Row of the current pixel |
| col_addr | output | 10 | Column of the current pixel |
| pix_valid | output | 4 | One-hot lane flag for the current pixel |
| line_done | output | 1 | High with the last pixel of a line |
| frame_done | output | 1 | High with the last pixel of a frame |

## Verification
The bench runs windows in all four corners, both interlace directions and all lane codes. It checks the first and last column, the width, the first two rows and the last row of each frame. A design with a swapped order bit starts at the wrong corner, and one with an off-by-one in the second interlace pass repeats or skips a row. Clipping and minimum-size cases use origins beyond the edge and undersized fields; an unclamped design reads past column 639 or produces too short a window. Configuration changes mid-frame, extra line-sync pulses inside a line and pulses after the frame's end must all leave the stream unchanged; a design that latches live settings or restarts a line would change the width or row.

// File: rtl/rdsq_pkg.sv
package rdsq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_LINE} seq_state_e;

  // number of output lanes selected by a lane code
  function automatic int unsigned lanes_of(input logic [1:0] code);
    if (code == 2'b00) return 1;
    if (code == 2'b01) return 2;
    return 4;
  endfunction

  // low-bit mask giving a column's lane index
  function automatic logic [1:0] lane_mask(input logic [1:0] code);
    if (code == 2'b00) return 2'b00;
    if (code == 2'b01) return 2'b01;
    return 2'b11;
  endfunction

  // window origin in pixels after snapping and minimum-size clamp
  function automatic int unsigned span_lo(input int unsigned start_f,
                                          input int unsigned unit,
                                          input int unsigned quantum,
                                          input int unsigned dim,
                                          input int unsigned min_sz);
    int unsigned st;
    st = ((start_f * unit) / quantum) * quantum;
    if (st > dim - min_sz) st = dim - min_sz;
    return st;
  endfunction

  // window end (exclusive) in pixels, clipped at the array edge
  function automatic int unsigned span_hi(input int unsigned start_f,
                                          input int unsigned size_f,
                                          input int unsigned unit,
                                          input int unsigned quantum,
                                          input int unsigned dim,
                                          input int unsigned min_sz);
    int unsigned sz;
    int unsigned en;
    sz = (size_f == 0) ? dim : size_f * unit;
    sz = (sz / quantum) * quantum;
    if (sz < min_sz) sz = min_sz;
    en = span_lo(start_f, unit, quantum, dim, min_sz) + sz;
    if (en > dim) en = dim;
    return en;
  endfunction

  // first row of a pass: phase 0 = first (or only) pass, phase 1 = odd rows
  function automatic int unsigned line_first(input int unsigned lo,
                                             input int unsigned hi,
                                             input logic inv,
                                             input logic il,
                                             input logic ph);
    if (!ph) return inv ? (il ? hi - 2 : hi - 1) : lo;
    return inv ? hi - 1 : lo + 1;
  endfunction

endpackage

// File: rtl/rdsq_geom.sv
module rdsq_geom
  import rdsq_pkg::*;
#(
  parameter int COLS      = 640,
  parameter int ROWS      = 512,
  parameter int UNIT      = 4,
  parameter int MIN_UNITS = 8,
  parameter int MIN_LINES = 8,
  parameter int CFW       = 8,
  parameter int RFW       = 7,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic [CFW-1:0] col_start_f,
  input  logic [CFW-1:0] col_size_f,
  input  logic [RFW-1:0] row_start_f,
  input  logic [RFW-1:0] row_size_f,
  input  logic [1:0]     lanes_code,
  output logic [CW-1:0]  col_lo,
  output logic [CW:0]    col_hi,
  output logic [RW-1:0]  row_lo,
  output logic [RW:0]    row_hi
);

  int unsigned quant;
  int unsigned min_w;

  always_comb begin
    quant  = UNIT * lanes_of(lanes_code);
    min_w  = MIN_UNITS * quant;
    col_lo = CW'(span_lo(32'(col_start_f), UNIT, quant, COLS, min_w));
    col_hi = (CW+1)'(span_hi(32'(col_start_f), 32'(col_size_f), UNIT, quant, COLS, min_w));
    row_lo = RW'(span_lo(32'(row_start_f), UNIT, UNIT, ROWS, MIN_LINES));
    row_hi = (RW+1)'(span_hi(32'(row_start_f), 32'(row_size_f), UNIT, UNIT, ROWS, MIN_LINES));
  end

endmodule

// File: rtl/rdsq_row_seq.sv
module rdsq_row_seq
  import rdsq_pkg::*;
#(
  parameter int ROWS = 512,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [RW-1:0] lo_in,
  input  logic [RW:0]   hi_in,
  input  logic          inv_in,
  input  logic          il_in,
  input  logic          advance,
  output logic [RW-1:0] row,
  output logic          last_row
);

  logic [RW-1:0] lo_q;
  logic [RW:0]   hi_q;
  logic          inv_q;
  logic          il_q;
  logic          ph_q;
  logic [RW-1:0] row_q;
  int unsigned   step;
  logic          pass_end;

  always_comb begin
    step     = il_q ? 2 : 1;
    pass_end = inv_q ? (32'(row_q) < 32'(lo_q) + step)
                     : (32'(row_q) + step >= 32'(hi_q));
    last_row = pass_end && (!il_q || ph_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= (RW+1)'(ROWS);
      inv_q <= 1'b0;
      il_q  <= 1'b0;
      ph_q  <= 1'b0;
      row_q <= '0;
    end else if (start) begin
      lo_q  <= lo_in;
      hi_q  <= hi_in;
      inv_q <= inv_in;
      il_q  <= il_in;
      ph_q  <= 1'b0;
      row_q <= RW'(line_first(32'(lo_in), 32'(hi_in), inv_in, il_in, 1'b0));
    end else if (advance && !last_row) begin
      if (pass_end) begin
        ph_q  <= 1'b1;
        row_q <= RW'(line_first(32'(lo_q), 32'(hi_q), inv_q, il_q, 1'b1));
      end else begin
        row_q <= RW'(inv_q ? 32'(row_q) - step : 32'(row_q) + step);
      end
    end
  end

  assign row = row_q;

  // R2: the row pointer never leaves the latched window
  p_row_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (row_q >= lo_q) && (32'(row_q) < 32'(hi_q)));

endmodule

// File: rtl/rdsq_col_seq.sv
module rdsq_col_seq
  import rdsq_pkg::*;
#(
  parameter int COLS  = 640,
  parameter int NLANE = 4,
  localparam int CW = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    lo_in,
  input  logic [CW:0]      hi_in,
  input  logic             rev_in,
  input  logic [1:0]       lanes_in,
  input  logic             load,
  input  logic             step_en,
  input  logic             active,
  output logic [CW-1:0]    col,
  output logic             last_col,
  output logic [NLANE-1:0] lane_vec
);

  logic [CW-1:0] lo_q;
  logic [CW:0]   hi_q;
  logic          rev_q;
  logic [1:0]    lanes_q;
  logic [CW-1:0] col_q;
  logic [1:0]    lane_idx;

  always_comb begin
    last_col = rev_q ? (col_q == lo_q) : (32'(col_q) + 1 == 32'(hi_q));
    lane_idx = col_q[1:0] & lane_mask(lanes_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      hi_q    <= (CW+1)'(COLS);
      rev_q   <= 1'b0;
      lanes_q <= 2'b00;
      col_q   <= '0;
    end else begin
      if (start) begin
        lo_q    <= lo_in;
        hi_q    <= hi_in;
        rev_q   <= rev_in;
        lanes_q <= lanes_in;
      end
      if (load)
        col_q <= CW'(rev_q ? 32'(hi_q) - 1 : 32'(lo_q));
      else if (step_en)
        col_q <= rev_q ? col_q - CW'(1) : col_q + CW'(1);
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_vec[g] = active && (lane_idx == 2'(g));
  end

  assign col = col_q;

  // R2: every pixel handed out lies in the latched window
  p_col_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((col_q >= lo_q) && (32'(col_q) < 32'(hi_q))));

  // R11: consecutive pixels differ by one column in the scan direction
  p_col_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !start) |=> (rev_q ? (col_q == $past(col_q) - CW'(1))
                                   : (col_q == $past(col_q) + CW'(1))));

endmodule

// File: rtl/rdsq_readout_seq.sv
module rdsq_readout_seq
  import rdsq_pkg::*;
#(
  parameter int COLS      = 640,
  parameter int ROWS      = 512,
  parameter int UNIT      = 4,
  parameter int MIN_UNITS = 8,
  parameter int MIN_LINES = 8,
  parameter int CFW       = 8,
  parameter int RFW       = 7,
  parameter int NLANE     = 4,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             lsync,
  input  logic [CFW-1:0]   cfg_col_start,
  input  logic [CFW-1:0]   cfg_col_size,
  input  logic [RFW-1:0]   cfg_row_start,
  input  logic [RFW-1:0]   cfg_row_size,
  input  logic [1:0]       cfg_order,
  input  logic             cfg_interlace,
  input  logic [1:0]       cfg_lanes,
  output logic [RW-1:0]    row_addr,
  output logic [CW-1:0]    col_addr,
  output logic [NLANE-1:0] pix_valid,
  output logic             line_done,
  output logic             frame_done
);

  seq_state_e state, state_d;
  logic fsync_q, lsync_q;
  logic fs_rise, ls_rise;
  logic line_active, line_load, col_step, row_adv;
  logic last_col, last_row;
  logic [CW-1:0] g_col_lo;
  logic [CW:0]   g_col_hi;
  logic [RW-1:0] g_row_lo;
  logic [RW:0]   g_row_hi;

  // named internal events
  assign fs_rise     = fsync & ~fsync_q;
  assign ls_rise     = lsync & ~lsync_q;
  assign line_active = (state == ST_LINE);
  assign line_load   = (state == ST_ARMED) && ls_rise && !fs_rise;
  assign col_step    = line_active && !last_col;
  assign line_done   = line_active && last_col;
  assign frame_done  = line_done && last_row;
  assign row_adv     = line_done && !fs_rise;

  rdsq_geom #(
    .COLS(COLS), .ROWS(ROWS), .UNIT(UNIT), .MIN_UNITS(MIN_UNITS),
    .MIN_LINES(MIN_LINES), .CFW(CFW), .RFW(RFW)
  ) geom_i (
    .col_start_f(cfg_col_start),
    .col_size_f (cfg_col_size),
    .row_start_f(cfg_row_start),
    .row_size_f (cfg_row_size),
    .lanes_code (cfg_lanes),
    .col_lo     (g_col_lo),
    .col_hi     (g_col_hi),
    .row_lo     (g_row_lo),
    .row_hi     (g_row_hi)
  );

  rdsq_row_seq #(.ROWS(ROWS)) rows_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (fs_rise),
    .lo_in   (g_row_lo),
    .hi_in   (g_row_hi),
    .inv_in  (cfg_order[0]),
    .il_in   (cfg_interlace),
    .advance (row_adv),
    .row     (row_addr),
    .last_row(last_row)
  );

  rdsq_col_seq #(.COLS(COLS), .NLANE(NLANE)) cols_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (fs_rise),
    .lo_in   (g_col_lo),
    .hi_in   (g_col_hi),
    .rev_in  (cfg_order[1]),
    .lanes_in(cfg_lanes),
    .load    (line_load),
    .step_en (col_step),
    .active  (line_active),
    .col     (col_addr),
    .last_col(last_col),
    .lane_vec(pix_valid)
  );

  always_comb begin
    state_d = state;
    if (fs_rise) begin
      state_d = ST_ARMED;
    end else begin
      case (state)
        ST_ARMED: if (ls_rise) state_d = ST_LINE;
        ST_LINE:  if (last_col) state_d = last_row ? ST_IDLE : ST_ARMED;
        default:  state_d = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      fsync_q <= 1'b0;
      lsync_q <= 1'b0;
    end else begin
      state   <= state_d;
      fsync_q <= fsync;
      lsync_q <= lsync;
    end
  end

  // R5: at most one lane carries a pixel in any cycle
  p_lane_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pix_valid));

  // R6: the cycle after the last pixel of a line carries no pixel
  p_gap_after_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> (pix_valid == '0));

  // R7: an idle sequencer stays silent unless a frame starts
  p_idle_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && !fs_rise) |=> (pix_valid == '0));

  // R11: the row is held for the whole line
  p_row_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (line_active && !line_done && !fs_rise) |=> ($stable(row_addr) && (pix_valid != '0)));

endmodule

// File: tb/rdsq_readout_seq_tb.sv
module rdsq_readout_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       lsync = 1'b0;
  logic [7:0] cfg_col_start = '0;
  logic [7:0] cfg_col_size = '0;
  logic [6:0] cfg_row_start = '0;
  logic [6:0] cfg_row_size = '0;
  logic [1:0] cfg_order = '0;
  logic       cfg_interlace = 1'b0;
  logic [1:0] cfg_lanes = '0;
  logic [8:0] row_addr;
  logic [9:0] col_addr;
  logic [3:0] pix_valid;
  logic       line_done;
  logic       frame_done;

  always #10 clk = ~clk;  // 50 MHz

  rdsq_readout_seq dut_i (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .lsync(lsync),
    .cfg_col_start(cfg_col_start), .cfg_col_size(cfg_col_size),
    .cfg_row_start(cfg_row_start), .cfg_row_size(cfg_row_size),
    .cfg_order(cfg_order), .cfg_interlace(cfg_interlace), .cfg_lanes(cfg_lanes),
    .row_addr(row_addr), .col_addr(col_addr), .pix_valid(pix_valid),
    .line_done(line_done), .frame_done(frame_done)
  );

  typedef struct packed {
    logic [7:0] cs; logic [7:0] csz; logic [6:0] rs; logic [6:0] rsz;
    logic [1:0] ord; logic il; logic [1:0] ln;
    int c0; int c1; int w; int r0; int r1; int rl; int n;
  } vec_t;

  // expected values worked out by hand from R2..R5
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'd2,   8'd8,   7'd1,   7'd2, 2'b00, 1'b0, 2'b00,   8,  39,  32,   4,   5,  11,  8},
    '{8'd2,   8'd8,   7'd1,   7'd2, 2'b01, 1'b0, 2'b00,   8,  39,  32,  11,  10,   4,  8},
    '{8'd2,   8'd8,   7'd1,   7'd2, 2'b10, 1'b0, 2'b00,  39,   8,  32,   4,   5,  11,  8},
    '{8'd2,   8'd8,   7'd1,   7'd2, 2'b11, 1'b0, 2'b00,  39,   8,  32,  11,  10,   4,  8},
    '{8'd2,   8'd8,   7'd1,   7'd2, 2'b00, 1'b1, 2'b00,   8,  39,  32,   4,   6,  11,  8},
    '{8'd2,   8'd8,   7'd1,   7'd2, 2'b01, 1'b1, 2'b00,   8,  39,  32,  10,   8,   5,  8},
    '{8'd3,   8'd4,   7'd0,   7'd2, 2'b10, 1'b0, 2'b01,  71,   8,  64,   0,   1,   7,  8},
    '{8'd159, 8'd200, 7'd127, 7'd5, 2'b11, 1'b0, 2'b10, 639, 512, 128, 511, 510, 504,  8},
    '{8'd1,   8'd33,  7'd2,   7'd3, 2'b00, 1'b1, 2'b11,   0, 127, 128,   8,  10,  19, 12},
    '{8'd10,  8'd0,   7'd126, 7'd4, 2'b01, 1'b0, 2'b00,  40, 639, 600, 511, 510, 504,  8}
  };

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // results of the last line
  int  g_first, g_last, g_w, g_row, g_err, g_lmask;
  bit  g_rev, g_fd, g_fd_stray, g_late;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic set_cfg(input vec_t v);
    cfg_col_start = v.cs; cfg_col_size = v.csz;
    cfg_row_start = v.rs; cfg_row_size = v.rsz;
    cfg_order = v.ord; cfg_interlace = v.il; cfg_lanes = v.ln;
  endtask

  // remember scan direction and lane mask of the settings being latched
  task automatic frame_start();
    g_rev   = cfg_order[1];
    g_lmask = (cfg_lanes == 2'b00) ? 0 : (cfg_lanes == 2'b01) ? 1 : 3;
    fsync = 1'b1;
    @(negedge clk);
    fsync = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_line(input bit extra);
    bit got;
    int prev;
    got = 1'b0; g_w = 0; g_err = 0; g_fd = 1'b0; g_fd_stray = 1'b0; g_late = 1'b0;
    prev = 0; g_first = -1; g_last = -1; g_row = -1;
    lsync = 1'b1;
    @(negedge clk);
    lsync = 1'b0;
    for (int i = 0; i < 2000 && !got; i++) begin
      if (extra && i == 5) lsync = 1'b1;
      if (extra && i == 6) lsync = 1'b0;
      if (frame_done && !line_done) g_fd_stray = 1'b1;
      if (pix_valid != 4'b0) begin
        if (g_w == 0) begin
          g_first = int'(col_addr);
          g_row = int'(row_addr);
        end else begin
          if (int'(row_addr) != g_row) g_err++;
          if (int'(col_addr) != (g_rev ? prev - 1 : prev + 1)) g_err++;
        end
        if (int'(pix_valid) != (1 << (int'(col_addr) & g_lmask))) g_err++;
        prev = int'(col_addr);
        g_last = prev;
        g_w++;
        if (line_done) begin
          got = 1'b1;
          g_fd = frame_done;
        end
      end else if (i == 0) begin
        g_late = 1'b1;
      end
      if (!got) @(negedge clk);
    end
    @(negedge clk);
  endtask

  // count pixels seen in a few cycles after a line-sync pulse
  task automatic quiet_pulse(output int seen);
    seen = 0;
    lsync = 1'b1;
    @(negedge clk);
    lsync = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (pix_valid != 4'b0 || line_done || frame_done) seen++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hang expected completion");
    finish_up();
  end

  initial begin
    int seen;
    int stray;
    int late;
    vec_t v;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 lanes in reset", int'(pix_valid), 0);
    chk("R1 line_done in reset", int'(line_done), 0);
    chk("R1 frame_done in reset", int'(frame_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    quiet_pulse(seen);
    chk("R1 line sync before any frame", seen, 0);

    // R2/R3: all-zero fields give the full window from the lower-left corner
    frame_start();
    run_line(1'b0);
    chk("R2 full width", g_w, 640);
    chk("R3 default first column", g_first, 0);
    chk("R3 default last column", g_last, 639);
    chk("R3 default first row", g_row, 0);
    chk("R6 first pixel one cycle after line sync", int'(g_late), 0);
    run_line(1'b0);
    chk("R3 default second row", g_row, 1);

    // R9: settings latched at frame start
    set_cfg(VECS[0]);
    frame_start();
    run_line(1'b0);
    set_cfg(VECS[7]);
    run_line(1'b0);
    chk("R9 width held after cfg change", g_w, 32);
    chk("R9 first column held", g_first, 8);
    chk("R9 row sequence held", g_row, 5);

    // R8: line sync inside a line
    run_line(1'b1);
    chk("R8 width with extra line sync", g_w, 32);
    chk("R8 row of that line", g_row, 6);
    run_line(1'b0);
    chk("R8 next line row", g_row, 7);

    // R10: frame sync mid-frame restarts at first row
    set_cfg(VECS[0]);
    frame_start();
    run_line(1'b0);
    chk("R10 restart row", g_row, 4);
    chk("R10 restart width", g_w, 32);

    // table of windows, orders, interlace and lane codes
    for (int k = 0; k < NV; k++) begin
      int r0, r1, rl, nl, err, fd_early;
      bit fd_last;
      v = VECS[k];
      set_cfg(v);
      frame_start();
      r0 = -1; r1 = -1; rl = -1; nl = 0; err = 0; fd_early = 0; fd_last = 1'b0;
      stray = 0; late = 0;
      for (int li = 0; li < v.n; li++) begin
        run_line(1'b0);
        if (li == 0) begin
          r0 = g_row;
          chk($sformatf("R2 vec%0d width", k), g_w, v.w);
          chk($sformatf("R3 vec%0d first column", k), g_first, v.c0);
          chk($sformatf("R3 vec%0d last column", k), g_last, v.c1);
        end
        if (li == 1) r1 = g_row;
        if (li == v.n - 1) begin
          rl = g_row;
          fd_last = g_fd;
        end else if (g_fd) begin
          fd_early++;
        end
        if (g_fd_stray) stray++;
        if (g_late) late++;
        err += g_err;
        nl++;
      end
      chk($sformatf("R3 vec%0d first row", k), r0, v.r0);
      chk($sformatf("R4 vec%0d second row", k), r1, v.r1);
      chk($sformatf("R4 vec%0d last row", k), rl, v.rl);
      chk($sformatf("R5 R11 vec%0d lane/row/step errors", k), err, 0);
      chk($sformatf("R6 vec%0d late first pixel", k), late, 0);
      chk($sformatf("R7 vec%0d frame_done on last line", k), int'(fd_last), 1);
      chk($sformatf("R7 vec%0d frame_done early", k), fd_early + stray, 0);
      quiet_pulse(seen);
      chk($sformatf("R7 vec%0d line sync after frame end", k), seen, 0);
    end

    finish_up();
  end

endmodule